// File: doc/BRIEF.md
# Extended Parallel-Port Control Bank with Test FIFO

This block is the secondary register window of a parallel-port controller. It holds three host-visible registers: a data register that doubles as the access point of a small byte FIFO, a free configuration byte, and an extended control register. The extended control register selects one of eight chip modes and reports how full the FIFO is. The host sees the bank through a single-cycle register interface. A read returns data combinationally in the cycle where `rd_en` is high. Any side effect of a read or a write takes place at the next rising clock edge.

The FIFO can only be reached in the FIFO test mode. In that mode, writes to offset 0 push bytes and reads from offset 0 pop them. In every other mode, offset 0 is an ordinary byte register. Any write that changes the mode empties the FIFO. This lets software fill and drain the FIFO and watch the status bits without moving anything over the cable.

Top module: `xcap_regbank`

## Requirements
- R1: After reset, offset 0 and offset 1 read 0x00, offset 2 reads 0x01 (compatibility mode, empty), and `mode_o` is 0.
- R2: A write to offset 2 loads its bits 7:5 into the mode, and `mode_o` follows. Bits 4:2 of offset 2 always read 0. Written bits 1:0 are ignored. The mode codes are: 0 compatibility, 1 byte, 2 parallel FIFO, 3 extended FIFO, 4 address/data strobe mode, 5 reserved, 6 FIFO test, 7 configuration.
- R3: Offset 2 bits 1:0 report FIFO status. 01 means empty, 10 means full and 00 means some data. The code 11 never appears.
- R4: In mode 6, a write to offset 0 on a FIFO that is not full stores the byte at the write pointer and advances the pointer. If the pointer reaches the depth (default 2), it wraps to 0 and the status becomes full. Otherwise the status becomes some-data.
- R5: In mode 6, a read of offset 0 on a FIFO that is not empty returns the entry at the read pointer and advances that pointer, wrapping at the depth. The status becomes empty if the new read pointer equals the write pointer, and some-data otherwise.
- R6: A write to offset 0 in mode 6 while the status is full changes neither the stored bytes nor the status.
- R7: A read of offset 0 in mode 6 while the status is empty returns the entry at the read pointer without advancing it, and the status stays empty.
- R8: Outside mode 6, offset 0 is a plain read/write byte register, separate from the FIFO storage. Accesses to it leave the FIFO status unchanged.
- R9: A write to offset 2 whose mode differs from the current mode resets both FIFO pointers and sets the status to empty. A write with the same mode leaves the status as it was.
- R10: Offset 1 is a plain read/write byte.
- R11: Offsets 3 to 7 read as all ones, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| addr | input | AW (3) | Register offset in the window |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data, valid while `rd_en` is high |
| mode_o | output | 3 | Current chip mode |

## Verification
Some properties are checked on every cycle by the assertions. Full and empty are never both set. A push while full leaves the write pointer and the full flag untouched. A pop while empty leaves the read pointer untouched. A mode change always lands on zeroed pointers with the empty flag set. The mode register moves only on a control write, and offsets 3 to 7 always read all ones.

Other behaviour only shows up across a sequence, so the bench scenarios carry it. These cover first-in-first-out byte order and the early full flag when the write pointer wraps after a pop. They also cover the stale byte returned by a pop while empty, the survival of the plain data byte across a stay in test mode, and reset in the middle of a run.

// File: rtl/xcap_pkg.sv
package xcap_pkg;

   typedef enum logic [2:0] {
      XM_COMPAT  = 3'd0,
      XM_BYTE    = 3'd1,
      XM_PPFIFO  = 3'd2,
      XM_XFIFO   = 3'd3,
      XM_ADSTRB  = 3'd4,
      XM_RSVD    = 3'd5,
      XM_FTEST   = 3'd6,
      XM_CONFIG  = 3'd7
   } xmode_e;

   localparam logic [1:0] ST_SOME  = 2'b00;
   localparam logic [1:0] ST_EMPTY = 2'b01;
   localparam logic [1:0] ST_FULL  = 2'b10;

   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_CFG  = 1;
   localparam int unsigned OFS_CTL  = 2;

   localparam int unsigned MODE_LSB = 5;
   localparam int unsigned MODE_W   = 3;

endpackage

// File: rtl/xcap_fifo.sv
module xcap_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic          empty_o,
   output logic          full_o
);

   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          POW2 = ((1 << PW) == DEPTH);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("xcap_fifo: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_dw_bad
         $error("xcap_fifo: DW must be positive");
      end
   endgenerate

   logic [PW-1:0] wptr, rptr;
   logic [PW-1:0] w_nxt, r_nxt;
   logic          w_wrap;
   logic          push_ok, pop_ok;
   logic [DEPTH-1:0][DW-1:0] ent;

   assign push_ok = push && !full_o && !flush;
   assign pop_ok  = pop && !empty_o && !flush && !push;
   assign w_wrap  = (wptr == LAST);

   generate
      if (POW2) begin : g_wrap_nat
         assign w_nxt = wptr + 1'b1;
         assign r_nxt = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign w_nxt = (wptr == LAST) ? '0 : wptr + 1'b1;
         assign r_nxt = (rptr == LAST) ? '0 : rptr + 1'b1;
      end
   endgenerate

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (push_ok && (wptr == PW'(g)))
               q <= wdata;
         end
         assign ent[g] = q;
      end
   endgenerate

   assign head = ent[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         empty_o <= 1'b1;
         full_o  <= 1'b0;
      end else if (flush) begin
         wptr    <= '0;
         rptr    <= '0;
         empty_o <= 1'b1;
         full_o  <= 1'b0;
      end else if (push_ok) begin
         wptr    <= w_nxt;
         full_o  <= w_wrap;
         empty_o <= 1'b0;
      end else if (pop_ok) begin
         rptr    <= r_nxt;
         empty_o <= (r_nxt == wptr);
         full_o  <= 1'b0;
      end
   end

   // R3
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));

   // R6
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full_o && !flush) |=> (full_o && $stable(wptr)));

   // R7
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty_o && !flush) |=> (empty_o && $stable(rptr)));

   // R9
   flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty_o && !full_o && wptr == '0 && rptr == '0));

   // R4
   push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full_o && !flush) |=> !empty_o);

endmodule

// File: rtl/xcap_mode_reg.sv
module xcap_mode_reg
   import xcap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [2:0] new_mode,
   output xmode_e     mode_q,
   output logic       flush_o
);

   assign flush_o = ctl_wr && (new_mode != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= XM_COMPAT;
      else if (ctl_wr)
         mode_q <= xmode_e'(new_mode);
   end

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(mode_q));

   // R2
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (mode_q == $past(new_mode)));

endmodule

// File: rtl/xcap_rd_mux.sv
module xcap_rd_mux
   import xcap_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 3
) (
   input  logic [AW-1:0] addr,
   input  logic          fifo_sel,
   input  logic [DW-1:0] data_q,
   input  logic [DW-1:0] cfg_q,
   input  logic [DW-1:0] head,
   input  xmode_e        mode,
   input  logic [1:0]    status,
   output logic [DW-1:0] rdata
);

   always_comb begin
      rdata = '1;
      if (addr == AW'(OFS_DATA)) begin
         rdata = fifo_sel ? head : data_q;
      end else if (addr == AW'(OFS_CFG)) begin
         rdata = cfg_q;
      end else if (addr == AW'(OFS_CTL)) begin
         rdata = '0;
         rdata[MODE_LSB +: MODE_W] = mode;
         rdata[1:0] = status;
      end
   end

endmodule

// File: rtl/xcap_regbank.sv
module xcap_regbank
   import xcap_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned AW    = 3,
   parameter int unsigned DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [2:0]    mode_o
);

   generate
      if (DW < 8) begin : g_dw_bad
         $error("xcap_regbank: DW must be at least 8");
      end
      if (AW < 2) begin : g_aw_bad
         $error("xcap_regbank: AW must be at least 2");
      end
   endgenerate

   logic          sel_data, sel_cfg, sel_ctl;
   logic          in_test;
   logic          push, pop, data_we, cfg_we, ctl_wr, flush;
   logic [DW-1:0] data_q, cfg_q, head;
   logic          f_empty, f_full;
   logic [1:0]    status;
   xmode_e        mode_q;

   assign sel_data = (addr == AW'(OFS_DATA));
   assign sel_cfg  = (addr == AW'(OFS_CFG));
   assign sel_ctl  = (addr == AW'(OFS_CTL));
   assign in_test  = (mode_q == XM_FTEST);

   assign push    = wr_en && sel_data && in_test;
   assign pop     = rd_en && sel_data && in_test;
   assign data_we = wr_en && sel_data && !in_test;
   assign cfg_we  = wr_en && sel_cfg;
   assign ctl_wr  = wr_en && sel_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (data_we) data_q <= wdata;
         if (cfg_we)  cfg_q  <= wdata;
      end
   end

   xcap_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .new_mode (wdata[MODE_LSB +: MODE_W]),
      .mode_q   (mode_q),
      .flush_o  (flush)
   );

   xcap_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .push    (push),
      .pop     (pop),
      .wdata   (wdata),
      .head    (head),
      .empty_o (f_empty),
      .full_o  (f_full)
   );

   assign status = f_full ? ST_FULL : (f_empty ? ST_EMPTY : ST_SOME);

   xcap_rd_mux #(.DW(DW), .AW(AW)) u_mux (
      .addr     (addr),
      .fifo_sel (in_test),
      .data_q   (data_q),
      .cfg_q    (cfg_q),
      .head     (head),
      .mode     (mode_q),
      .status   (status),
      .rdata    (rdata)
   );

   assign mode_o = mode_q;

   // R11
   hi_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr > AW'(OFS_CTL)) |-> (rdata == '1));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_data && in_test) |=> $stable(data_q));

   // host issues one access per cycle
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));

endmodule

// File: tb/xcap_regbank_tb.sv
module xcap_regbank_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [2:0] mode_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xcap_regbank u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .mode_o (mode_o)
   );

   // vector: {rd, addr[2:0], data/expect[7:0], req[3:0]}
   localparam int NV = 38;
   localparam logic [15:0] VEC [0:NV-1] = '{
      {1'b0, 3'd2, 8'hDF, 4'd2},  // R2 enter test mode, junk in low bits
      {1'b1, 3'd2, 8'hC1, 4'd2},  // R2 R3 mode 6, empty
      {1'b0, 3'd0, 8'hAA, 4'd4},  // R4 push
      {1'b1, 3'd2, 8'hC0, 4'd4},  // R4 some data
      {1'b0, 3'd0, 8'h55, 4'd4},  // R4 push, pointer wraps
      {1'b1, 3'd2, 8'hC2, 4'd4},  // R4 full
      {1'b0, 3'd0, 8'h77, 4'd6},  // R6 push while full
      {1'b1, 3'd2, 8'hC2, 4'd6},  // R6 still full
      {1'b1, 3'd0, 8'hAA, 4'd5},  // R5 first out
      {1'b1, 3'd2, 8'hC0, 4'd5},  // R5 some data
      {1'b1, 3'd0, 8'h55, 4'd6},  // R6 second byte not overwritten
      {1'b1, 3'd2, 8'hC1, 4'd5},  // R5 empty
      {1'b1, 3'd0, 8'hAA, 4'd7},  // R7 stale entry
      {1'b1, 3'd2, 8'hC1, 4'd7},  // R7 still empty
      {1'b1, 3'd0, 8'hAA, 4'd7},  // R7 pointer did not move
      {1'b0, 3'd0, 8'h12, 4'd4},  // R4
      {1'b1, 3'd0, 8'h12, 4'd5},  // R5
      {1'b0, 3'd0, 8'h34, 4'd4},  // R4 pointer reaches depth after pop
      {1'b1, 3'd2, 8'hC2, 4'd4},  // R4 flagged full on wrap
      {1'b1, 3'd0, 8'h34, 4'd5},  // R5
      {1'b1, 3'd2, 8'hC1, 4'd5},  // R5 empty again
      {1'b0, 3'd0, 8'h56, 4'd4},  // R4
      {1'b0, 3'd2, 8'hC3, 4'd9},  // R9 same mode
      {1'b1, 3'd2, 8'hC0, 4'd9},  // R9 no flush
      {1'b0, 3'd2, 8'h20, 4'd9},  // R9 change to mode 1
      {1'b1, 3'd2, 8'h21, 4'd9},  // R9 flushed
      {1'b0, 3'd0, 8'h9C, 4'd8},  // R8 plain data
      {1'b1, 3'd0, 8'h9C, 4'd8},  // R8
      {1'b1, 3'd2, 8'h21, 4'd8},  // R8 fifo untouched
      {1'b0, 3'd1, 8'h5A, 4'd10}, // R10
      {1'b1, 3'd1, 8'h5A, 4'd10}, // R10
      {1'b0, 3'd5, 8'h00, 4'd11}, // R11 write ignored
      {1'b1, 3'd5, 8'hFF, 4'd11}, // R11
      {1'b1, 3'd3, 8'hFF, 4'd11}, // R11
      {1'b1, 3'd7, 8'hFF, 4'd11}, // R11
      {1'b1, 3'd1, 8'h5A, 4'd11}, // R11 cfg unaffected
      {1'b0, 3'd2, 8'h00, 4'd8},  // R8 back to mode 0
      {1'b1, 3'd0, 8'h9C, 4'd8}   // R8 data survived
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic reset_checks(input string tag);
      logic [7:0] v;
      do_rd(3'd0, v); check(tag, v, 8'h00);
      do_rd(3'd1, v); check(tag, v, 8'h00);
      do_rd(3'd2, v); check(tag, v, 8'h01);
      check(tag, {5'd0, mode_o}, 8'h00);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      reset_checks("R1 reset");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][15]) begin
            do_rd(VEC[i][14:12], v);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][11:4]);
         end else begin
            do_wr(VEC[i][14:12], VEC[i][11:4]);
         end
      end

      // R2 mode output follows control write
      do_wr(3'd2, 8'hE0);
      check("R2 mode_o", {5'd0, mode_o}, 8'h07);
      do_rd(3'd2, v); check("R2 cfg mode", v, 8'hE1);

      // R8 data writes in test mode go to fifo, not plain register
      do_wr(3'd0, 8'h3C);
      do_wr(3'd2, 8'hC0);
      do_wr(3'd0, 8'hF0);
      do_wr(3'd2, 8'h00);
      do_rd(3'd0, v); check("R8 plain kept", v, 8'h3C);

      // R9 flush mid-fill then refill starts at slot 0
      do_wr(3'd2, 8'hC0);
      do_wr(3'd0, 8'h01);
      do_wr(3'd2, 8'h40);
      do_wr(3'd2, 8'hC0);
      do_rd(3'd2, v); check("R9 flushed", v, 8'hC1);
      do_wr(3'd0, 8'h02);
      do_rd(3'd0, v); check("R9 refill order", v, 8'h02);

      // R1 reset in the middle of activity
      do_wr(3'd1, 8'h77);
      do_wr(3'd0, 8'h66);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      reset_checks("R1 mid reset");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule